// File: doc/BRIEF.md
# Leaf Power-Level Request Agent

This block sits at a leaf of a tree-shaped power manager and stands for one computing resource. It holds that resource's present power level, which is one of five ordered settings from lowest to highest. When the local workload asks for a different level, the agent sends a single request pulse to its parent controller. It then enters a waiting state tied to the level it asked for. The parent answers with either a grant or a denial. On a grant the agent takes the new level. On a denial it keeps the old one. In both cases it answers with a one-cycle acknowledge.

When the retry mode is on, a denial is followed at once by a fresh request for the level one step below the one just refused. Workload requests that arrive while the agent is waiting go into a single holding slot, where a newer request replaces an older one. The slot is served as soon as the agent is idle again.

Top module: `pwr_leaf_agent`

## Requirements
- R1: After reset, `cur_level` is 0 (lowest), `pending` is 0, and `req_valid` and `ack` are both 0.
- R2: Levels are 3-bit codes: 0 lowest, 1 medium-low, 2 medium, 3 medium-high, 4 highest. `cur_level` and `req_level` never carry 5, 6 or 7. A workload request with code 5 to 7 is ignored: no request is sent and no waiting state is entered.
- R3: While idle, a legal `want_level` that differs from `cur_level` and is presented with `want_valid` gives a `req_valid` pulse one cycle long in the next cycle, with `req_level` equal to the wanted code. `pending` is 1 from that same cycle onward.
- R4: While idle, a workload request equal to `cur_level` is ignored: no `req_valid`, and `pending` stays 0.
- R5: When a grant is sampled while waiting, then in the next cycle `cur_level` equals the requested code, `ack` is 1 for exactly that cycle, and `pending` is 0 unless a retry was issued.
- R6: When a denial is sampled while waiting and the retry mode is off, then in the next cycle `cur_level` is unchanged, `ack` is 1, `pending` is 0, and no request is sent.
- R7: When a denial is sampled with `retry_en` = 1, the denied code is above 0, and the code one below it differs from `cur_level`, then in the same cycle as `ack` a new `req_valid` pulse carries the denied code minus one, and `pending` stays 1.
- R8: With `retry_en` = 1, a denial of a request for code 0 gives no retry. A denial whose code minus one equals `cur_level` also gives no retry. In both cases the agent goes idle.
- R9: A legal workload request that arrives while waiting is stored in a one-entry slot, and a later one overwrites it. In the cycle after the closing `ack`, the stored code is issued as a request if it differs from the new `cur_level`. Otherwise it is dropped.
- R10: A grant or denial that arrives while the agent is not waiting has no effect: `ack` stays 0 and `cur_level` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| retry_en | input | 1 | 1 = after a denial, step down one level and retry |
| want_valid | input | 1 | Workload presents a new level wish this cycle |
| want_level | input | 3 | Wished level code |
| rsp_grant | input | 1 | Parent grants the outstanding request |
| rsp_deny | input | 1 | Parent denies the outstanding request |
| req_valid | output | 1 | One-cycle request pulse to the parent |
| req_level | output | 3 | Level code carried by the request |
| ack | output | 1 | One-cycle acknowledge of a grant or denial |
| cur_level | output | 3 | Level presently held by the resource |
| pending | output | 1 | A request is outstanding |

## Verification
The bench sweeps every starting level against every 3-bit wish code, with both parent answers and both retry settings. This catches a design that sends requests for illegal codes, which would let the level register reach 5 to 7. It also catches one that re-requests the level it already holds. The corner cases it targets are:
- A denial at the bottom code, and a denial whose step-down lands on the level already held. A design wrong here would wrap the code below zero, or send a pointless request.
- Holding-slot overwrite and drop. A design wrong here would issue the older wish or re-request the new level.
- Stray answers while idle. A design wrong here would pulse `ack` or change level on them.

// File: rtl/pwr_leaf_pkg.sv
package pwr_leaf_pkg;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_MAX_CODE = 3'd4;

    typedef enum logic [LVL_W-1:0] {
        LV_LO  = 3'd0,
        LV_MLO = 3'd1,
        LV_MID = 3'd2,
        LV_MHI = 3'd3,
        LV_HI  = 3'd4
    } level_t;

    // One waiting state per requested level; code of the state equals level code.
    typedef enum logic [LVL_W-1:0] {
        ST_WAIT_LO  = 3'd0,
        ST_WAIT_MLO = 3'd1,
        ST_WAIT_MID = 3'd2,
        ST_WAIT_MHI = 3'd3,
        ST_WAIT_HI  = 3'd4,
        ST_IDLE     = 3'd5
    } state_t;

    function automatic logic lvl_legal(input logic [LVL_W-1:0] code);
        return code <= LVL_MAX_CODE;
    endfunction

    function automatic state_t wait_on(input level_t lvl);
        return state_t'(lvl);
    endfunction

    function automatic level_t lvl_of(input state_t st);
        return level_t'(st);
    endfunction

    function automatic level_t lvl_below(input level_t lvl);
        return (lvl == LV_LO) ? LV_LO : level_t'(lvl - 3'd1);
    endfunction

endpackage

// File: rtl/pwr_leaf_hold.sv
module pwr_leaf_hold
    import pwr_leaf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  level_t load_level,
    input  logic   take,
    output logic   valid,
    output level_t level
);

    logic   valid_q;
    level_t level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            level_q <= LV_LO;
        end else if (load) begin
            valid_q <= 1'b1;
            level_q <= load_level;
        end else if (take) begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign level = level_q;

    // R9
    hold_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (valid && level == $past(load_level)));

    // R9
    hold_take_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !load) |=> !valid);

endmodule

// File: rtl/pwr_leaf_pick.sv
module pwr_leaf_pick
    import pwr_leaf_pkg::*;
(
    input  logic               idle,
    input  level_t             cur,
    input  logic               want_valid,
    input  logic [LVL_W-1:0]   want_level,
    input  logic               hold_valid,
    input  level_t             hold_level,
    output logic               issue,
    output level_t             issue_level,
    output logic               hold_load,
    output logic               hold_take
);

    logic   want_ok;
    level_t cand;
    logic   cand_ok;

    always_comb begin
        want_ok = want_valid && lvl_legal(want_level);
        if (want_ok) begin
            cand    = level_t'(want_level);
            cand_ok = 1'b1;
        end else begin
            cand    = hold_level;
            cand_ok = hold_valid;
        end
        issue       = idle && cand_ok && (cand != cur);
        issue_level = cand;
        hold_load   = !idle && want_ok;
        hold_take   = idle && hold_valid;
    end

endmodule

// File: rtl/pwr_leaf_fsm.sv
module pwr_leaf_fsm
    import pwr_leaf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   retry_en,
    input  logic   issue,
    input  level_t issue_level,
    input  logic   rsp_grant,
    input  logic   rsp_deny,
    output logic   idle,
    output level_t cur,
    output logic   req_valid,
    output level_t req_level,
    output logic   ack
);

    state_t state_q;
    level_t cur_q;
    logic   req_q;
    level_t req_lvl_q;
    logic   ack_q;

    level_t wait_lvl;
    level_t step_lvl;
    logic   answered;
    logic   do_retry;

    always_comb begin
        wait_lvl = lvl_of(state_q);
        step_lvl = lvl_below(wait_lvl);
        answered = (state_q != ST_IDLE) && (rsp_grant || rsp_deny);
        do_retry = answered && !rsp_grant && retry_en &&
                   (wait_lvl != LV_LO) && (step_lvl != cur_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cur_q     <= LV_LO;
            req_q     <= 1'b0;
            req_lvl_q <= LV_LO;
            ack_q     <= 1'b0;
        end else begin
            req_q <= 1'b0;
            ack_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (issue) begin
                    state_q   <= wait_on(issue_level);
                    req_q     <= 1'b1;
                    req_lvl_q <= issue_level;
                end
            end else if (answered) begin
                ack_q <= 1'b1;
                if (rsp_grant) begin
                    cur_q   <= wait_lvl;
                    state_q <= ST_IDLE;
                end else if (do_retry) begin
                    state_q   <= wait_on(step_lvl);
                    req_q     <= 1'b1;
                    req_lvl_q <= step_lvl;
                end else begin
                    state_q <= ST_IDLE;
                end
            end
        end
    end

    assign idle      = (state_q == ST_IDLE);
    assign cur       = cur_q;
    assign req_valid = req_q;
    assign req_level = req_lvl_q;
    assign ack       = ack_q;

    // R2
    level_legal_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_legal(cur_q) && lvl_legal(req_lvl_q));

    // R3
    req_while_wait_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |-> !idle);

    // R4
    req_differs_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |-> (req_lvl_q != cur_q));

    // R5
    grant_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle && rsp_grant) |=> (ack && cur_q == $past(wait_lvl)));

    // R6
    deny_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle && rsp_deny && !rsp_grant) |=> (ack && $stable(cur_q)));

    // R8
    no_retry_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!idle && rsp_deny && !rsp_grant && wait_lvl == LV_LO) |=> (!req_q && idle));

    // R10
    stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && (rsp_grant || rsp_deny)) |=> (!ack && $stable(cur_q)));

endmodule

// File: rtl/pwr_leaf_agent.sv
module pwr_leaf_agent
    import pwr_leaf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             retry_en,
    input  logic             want_valid,
    input  logic [LVL_W-1:0] want_level,
    input  logic             rsp_grant,
    input  logic             rsp_deny,
    output logic             req_valid,
    output logic [LVL_W-1:0] req_level,
    output logic             ack,
    output logic [LVL_W-1:0] cur_level,
    output logic             pending
);

    logic   idle;
    level_t cur;
    level_t req_lvl;
    logic   hold_valid;
    level_t hold_level;
    logic   issue;
    level_t issue_level;
    logic   hold_load;
    logic   hold_take;

    pwr_leaf_pick pick_i (
        .idle        (idle),
        .cur         (cur),
        .want_valid  (want_valid),
        .want_level  (want_level),
        .hold_valid  (hold_valid),
        .hold_level  (hold_level),
        .issue       (issue),
        .issue_level (issue_level),
        .hold_load   (hold_load),
        .hold_take   (hold_take)
    );

    pwr_leaf_hold hold_i (
        .clk        (clk),
        .rst        (rst),
        .load       (hold_load),
        .load_level (level_t'(want_level)),
        .take       (hold_take),
        .valid      (hold_valid),
        .level      (hold_level)
    );

    pwr_leaf_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .retry_en    (retry_en),
        .issue       (issue),
        .issue_level (issue_level),
        .rsp_grant   (rsp_grant),
        .rsp_deny    (rsp_deny),
        .idle        (idle),
        .cur         (cur),
        .req_valid   (req_valid),
        .req_level   (req_lvl),
        .ack         (ack)
    );

    assign req_level = req_lvl;
    assign cur_level = cur;
    assign pending   = !idle;

    // R2
    illegal_want_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && want_valid && !lvl_legal(want_level) && !hold_valid) |=> !req_valid);

endmodule

// File: tb/pwr_leaf_agent_tb.sv
module pwr_leaf_agent_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       retry_en;
    logic       want_valid;
    logic [2:0] want_level;
    logic       rsp_grant;
    logic       rsp_deny;
    logic       req_valid;
    logic [2:0] req_level;
    logic       ack;
    logic [2:0] cur_level;
    logic       pending;

    int checks = 0;
    int fails  = 0;
    int exp_cur = 0;

    always #2.5 clk = ~clk;

    pwr_leaf_agent dut_i (
        .clk        (clk),
        .rst        (rst),
        .retry_en   (retry_en),
        .want_valid (want_valid),
        .want_level (want_level),
        .rsp_grant  (rsp_grant),
        .rsp_deny   (rsp_deny),
        .req_valid  (req_valid),
        .req_level  (req_level),
        .ack        (ack),
        .cur_level  (cur_level),
        .pending    (pending)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Move the agent to level lv through a granted request.
    task automatic go_to(input int lv);
        if (exp_cur != lv) begin
            want_valid = 1'b1; want_level = 3'(lv);
            cyc();
            want_valid = 1'b0;
            cyc();
            rsp_grant = 1'b1;
            cyc();
            rsp_grant = 1'b0;
            exp_cur = lv;
            cyc();
        end
    endtask

    task automatic sweep_one(input int c, input int w, input bit grant, input bit opt);
        retry_en = opt;
        go_to(c);
        want_valid = 1'b1; want_level = 3'(w);
        cyc();
        want_valid = 1'b0;
        if (w > 4 || w == c) begin
            // R2 R4: nothing sent
            chk("R2_R4 req_valid", int'(req_valid), 0);
            chk("R2_R4 pending", int'(pending), 0);
            cyc();
            chk("R2_R4 cur", int'(cur_level), exp_cur);
        end else begin
            chk("R3 req_valid", int'(req_valid), 1);
            chk("R3 req_level", int'(req_level), w);
            chk("R3 pending", int'(pending), 1);
            cyc();
            chk("R3 pulse width", int'(req_valid), 0);
            if (grant) rsp_grant = 1'b1; else rsp_deny = 1'b1;
            cyc();
            rsp_grant = 1'b0; rsp_deny = 1'b0;
            chk("R5_R6 ack", int'(ack), 1);
            if (grant) begin
                exp_cur = w;
                chk("R5 cur", int'(cur_level), w);
                chk("R5 pending", int'(pending), 0);
                chk("R5 req", int'(req_valid), 0);
                cyc();
                chk("R5 ack pulse", int'(ack), 0);
            end else begin
                chk("R6 cur kept", int'(cur_level), c);
                if (opt && w != 0 && (w - 1) != c) begin
                    chk("R7 retry req", int'(req_valid), 1);
                    chk("R7 retry level", int'(req_level), w - 1);
                    chk("R7 pending", int'(pending), 1);
                    cyc();
                    chk("R7 ack pulse", int'(ack), 0);
                    rsp_grant = 1'b1;
                    cyc();
                    rsp_grant = 1'b0;
                    exp_cur = w - 1;
                    chk("R7 retry granted", int'(cur_level), w - 1);
                    cyc();
                end else begin
                    // R6 R8: no retry
                    chk("R6_R8 no req", int'(req_valid), 0);
                    chk("R6_R8 pending", int'(pending), 0);
                    cyc();
                    chk("R6_R8 ack pulse", int'(ack), 0);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; retry_en = 1'b0; want_valid = 1'b0; want_level = 3'd0;
        rsp_grant = 1'b0; rsp_deny = 1'b0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1
        chk("R1 cur", int'(cur_level), 0);
        chk("R1 pending", int'(pending), 0);
        chk("R1 req", int'(req_valid), 0);
        chk("R1 ack", int'(ack), 0);

        // R10: stray answers while idle
        rsp_grant = 1'b1; cyc();
        rsp_grant = 1'b0; rsp_deny = 1'b1; cyc();
        rsp_deny = 1'b0;
        chk("R10 ack", int'(ack), 0);
        chk("R10 cur", int'(cur_level), 0);
        cyc();
        chk("R10 ack late", int'(ack), 0);

        for (int c = 0; c < 5; c++)
            for (int w = 0; w < 8; w++)
                for (int g = 0; g < 2; g++)
                    for (int o = 0; o < 2; o++)
                        sweep_one(c, w, g[0], o[0]);

        // R9: overwrite while waiting, served after denial closes
        retry_en = 1'b0;
        go_to(0);
        want_valid = 1'b1; want_level = 3'd4; cyc();
        chk("R9 first req", int'(req_level), 4);
        want_level = 3'd2; cyc();
        want_level = 3'd3; cyc();
        want_level = 3'd7; cyc();
        want_valid = 1'b0; rsp_deny = 1'b1; cyc();
        rsp_deny = 1'b0;
        chk("R9 ack", int'(ack), 1);
        chk("R9 idle after deny", int'(pending), 0);
        cyc();
        chk("R9 held req", int'(req_valid), 1);
        chk("R9 latest wins", int'(req_level), 3);
        rsp_grant = 1'b1; cyc();
        rsp_grant = 1'b0; exp_cur = 3;
        chk("R9 held granted", int'(cur_level), 3);
        cyc();

        // R9: stored wish equal to new level is dropped
        want_valid = 1'b1; want_level = 3'd1; cyc();
        want_level = 3'd1; cyc();
        want_valid = 1'b0; rsp_grant = 1'b1; cyc();
        rsp_grant = 1'b0; exp_cur = 1;
        chk("R9 cur", int'(cur_level), 1);
        cyc();
        chk("R9 dropped req", int'(req_valid), 0);
        chk("R9 dropped pending", int'(pending), 0);
        cyc();
        chk("R9 still idle", int'(pending), 0);

        // R8: retry step lands on held level
        retry_en = 1'b1;
        want_valid = 1'b1; want_level = 3'd2; cyc();
        want_valid = 1'b0; rsp_deny = 1'b1; cyc();
        rsp_deny = 1'b0;
        chk("R8 no retry onto held", int'(req_valid), 0);
        chk("R8 cur", int'(cur_level), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule